// File: doc/BRIEF.md
# Timed Uplink Response Framer

This block produces the reply a passive low-frequency tag sends back to a reader. It drives one coil-modulation output. A single-cycle start pulse marks the moment the reader frame ends, which is taken as the reader's last rising edge. The block then stays quiet for a fixed response delay, counted in carrier periods. The specified turnaround of 208 carrier periods is referenced to the reader's falling edge, so the wait is shortened by the gap length. After the delay the block sends a start-of-frame of five 1 bits and then the payload bits taken from a byte buffer. When the last bit has gone out it releases the output and raises a one-cycle done strobe.

Bits are Manchester coded. A bit lasts `BIT_CP` carrier periods. A 1 bit modulates the coil in its first half and a 0 bit modulates it in its second half. The carrier period length in clock cycles, the frame length in bits and the payload bytes are all captured when the start pulse is accepted, so the caller may change them once the reply is under way.

The controller has four states. `ST_IDLE` is the rest state, with the coil released. `ST_WAIT` counts the response delay. `ST_SEND` steps through the bits. `ST_DONE` lasts one cycle and raises the strobe. The transitions are:
- IDLE→WAIT when a start pulse arrives.
- WAIT→SEND when the last carrier period of the delay ends.
- SEND→SEND at every bit boundary except the last.
- SEND→DONE at the end of the final bit.
- DONE→IDLE unconditionally.

Top module: `reply_framer`

## Requirements
- R1: While reset is held and after it is released with no start pulse, `mod_o` and `done_o` are both 0.
- R2: `mod_o` stays 0 from the accepted start pulse until exactly (WRESP_CP − GAP_CP) × P clock cycles after it, where P is the captured carrier length. The first modulated cycle is that cycle.
- R3: Every reply opens with five 1 bits before any payload bit.
- R4: Each bit lasts BIT_CP × P cycles. A 1 bit drives `mod_o` high for the first BIT_CP/2 carrier periods and low for the rest. A 0 bit drives it low for the first half and high for the second half.
- R5: Payload bit i is taken from byte i/8 at bit position 7 − (i mod 8), so each byte is sent MSB first. Byte k sits on `payload_i[8k+7:8k]`.
- R6: `done_o` is high for exactly one cycle. That cycle immediately follows the last bit, with `mod_o` low. The block is idle on the next cycle.
- R7: A start pulse that arrives while a reply is being timed or sent is ignored. Changes to `len_bits_i`, `payload_i` or `carrier_clks_i` after acceptance do not alter the reply.
- R8: A frame length above MAX_BYTES × 8 is clamped to MAX_BYTES × 8. A length of 0 sends only the five start-of-frame bits.
- R9: A carrier length of 0 clocks is treated as 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Reader frame has ended; begin the reply |
| len_bits_i | input | $clog2(MAX_BYTES*8+1) | Payload length in bits |
| payload_i | input | MAX_BYTES*8 | Payload bytes, byte k at [8k+7:8k] |
| carrier_clks_i | input | CLK_W | Clock cycles per carrier period |
| mod_o | output | 1 | Coil modulation, 1 = modulated |
| done_o | output | 1 | One-cycle strobe after the reply |

## Verification
The bench builds the block with BIT_CP = 4, WRESP_CP = 12, GAP_CP = 2 and MAX_BYTES = 2. A full 16-bit reply then takes only a few hundred cycles, which makes it practical to compare every cycle of the waveform against a model. The small byte count also means the 5-bit length field can request more than the maximum, so the clamp can be exercised. Carrier lengths of 0, 1, 2 and 3 clocks show that the delay and bit timing scale with the captured period. Start pulses and input changes during both the wait and the send phases test that the captured frame is preserved.

// File: rtl/reply_framer_pkg.sv
`timescale 1ns/1ps
package reply_framer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND,
        ST_DONE
    } frm_state_t;
endpackage

// File: rtl/carrier_ticker.sv
`timescale 1ns/1ps
// Divides the clock into carrier periods; tick_o marks the last clock of each.
module carrier_ticker #(
    parameter int CLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CLK_W-1:0] period_i,
    output logic             tick_o
);
    logic [CLK_W-1:0] cnt;

    assign tick_o = !clear_i && (cnt == period_i - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clear_i) cnt <= '0;
        else if (tick_o)  cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // R9: the phase counter never passes the captured period
    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (cnt < period_i));
endmodule

// File: rtl/reply_bit_sel.sv
`timescale 1ns/1ps
// Maps a frame bit index onto start-of-frame or payload bit (MSB first per byte).
module reply_bit_sel #(
    parameter int SOF_BITS  = 5,
    parameter int MAX_BYTES = 4,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0]       bit_idx_i,
    input  logic [MAX_BYTES*8-1:0] payload_i,
    output logic                   bit_o
);
    localparam int MAX_BITS = MAX_BYTES * 8;

    always_comb begin
        int pidx;
        int pos;
        bit_o = 1'b1;
        pidx  = int'(bit_idx_i) - SOF_BITS;
        pos   = 8 * (pidx / 8) + 7 - (pidx % 8);
        if (int'(bit_idx_i) >= SOF_BITS) begin
            if (pidx < MAX_BITS) bit_o = payload_i[pos];
            else                 bit_o = 1'b0;
        end
    end
endmodule

// File: rtl/reply_framer.sv
`timescale 1ns/1ps
module reply_framer
    import reply_framer_pkg::*;
#(
    parameter int CLK_W     = 8,
    parameter int BIT_CP    = 32,
    parameter int GAP_CP    = 4,
    parameter int WRESP_CP  = 208,
    parameter int SOF_BITS  = 5,
    parameter int MAX_BYTES = 4,
    localparam int MAX_BITS = MAX_BYTES * 8,
    localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [LEN_W-1:0]     len_bits_i,
    input  logic [MAX_BITS-1:0]  payload_i,
    input  logic [CLK_W-1:0]     carrier_clks_i,
    output logic                 mod_o,
    output logic                 done_o
);
    localparam int DELAY_CP = WRESP_CP - GAP_CP;
    localparam int CP_MAX   = (DELAY_CP > BIT_CP) ? DELAY_CP : BIT_CP;
    localparam int CP_W     = $clog2(CP_MAX + 1);
    localparam int IDX_W    = $clog2(MAX_BITS + SOF_BITS + 1);
    localparam int HALF_CP  = BIT_CP / 2;
    localparam logic [CP_W-1:0]  DELAY_LAST = CP_W'(DELAY_CP - 1);
    localparam logic [CP_W-1:0]  BIT_LAST   = CP_W'(BIT_CP - 1);
    localparam logic [CP_W-1:0]  HALF_MARK  = CP_W'(HALF_CP);
    localparam logic [LEN_W-1:0] LEN_CAP    = LEN_W'(MAX_BITS);

    frm_state_t            state;
    logic [CP_W-1:0]       cp_cnt;
    logic [IDX_W-1:0]      bit_idx;
    logic [IDX_W-1:0]      total_q;
    logic [MAX_BITS-1:0]   payload_q;
    logic [CLK_W-1:0]      period_q;
    logic                  tick;
    logic                  cur_bit;
    logic [LEN_W-1:0]      len_eff;

    assign len_eff = (len_bits_i > LEN_CAP) ? LEN_CAP : len_bits_i;

    carrier_ticker #(.CLK_W(CLK_W)) u_ticker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state == ST_IDLE),
        .period_i (period_q),
        .tick_o   (tick)
    );

    reply_bit_sel #(.SOF_BITS(SOF_BITS), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_bitsel (
        .bit_idx_i (bit_idx),
        .payload_i (payload_q),
        .bit_o     (cur_bit)
    );

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cp_cnt    <= '0;
            bit_idx   <= '0;
            total_q   <= '0;
            payload_q <= '0;
            period_q  <= CLK_W'(1);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state     <= ST_WAIT;
                        cp_cnt    <= '0;
                        bit_idx   <= '0;
                        total_q   <= IDX_W'(SOF_BITS) + IDX_W'(len_eff);
                        payload_q <= payload_i;
                        period_q  <= (carrier_clks_i == '0) ? CLK_W'(1) : carrier_clks_i;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (cp_cnt == DELAY_LAST) begin
                            state  <= ST_SEND;
                            cp_cnt <= '0;
                        end else begin
                            cp_cnt <= cp_cnt + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (cp_cnt == BIT_LAST) begin
                            cp_cnt <= '0;
                            if (bit_idx == total_q - 1'b1) state   <= ST_DONE;
                            else                           bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cp_cnt <= cp_cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mod_o  = 1'b0;
        done_o = 1'b0;
        unique case (state)
            ST_SEND: mod_o  = cur_bit ? (cp_cnt < HALF_MARK) : (cp_cnt >= HALF_MARK);
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    // R6: strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: strobe only follows the sending phase
    a_r6_done_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state) == ST_SEND));
    // R2: the delay leads only into sending
    a_r2_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_SEND));
    // R3: bit index stays inside the captured frame
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (bit_idx < total_q));
    // R7: a start while busy leaves the captured frame untouched
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_i) |=>
            ($stable(total_q) && $stable(payload_q) && $stable(period_q)));
endmodule

// File: tb/tb_reply_framer.sv
`timescale 1ns/1ps
module tb_reply_framer;
    localparam int BIT   = 4;
    localparam int WRESP = 12;
    localparam int GAP   = 2;
    localparam int NBYTE = 2;
    localparam int SOF   = 5;
    localparam int MAXB  = NBYTE * 8;
    localparam int D     = WRESP - GAP;

    typedef struct packed {
        logic [4:0]  len;
        logic [15:0] pay;
        logic [7:0]  per;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd8,  16'h00A5, 8'd2},   // R5 one byte
        '{5'd16, 16'h3C81, 8'd1},   // R5 two bytes, byte order
        '{5'd3,  16'h00A0, 8'd3},   // partial byte
        '{5'd0,  16'hFFFF, 8'd2},   // R8 zero length
        '{5'd31, 16'h12F0, 8'd2},   // R8 clamp to 16
        '{5'd5,  16'h0058, 8'd0}    // R9 period 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  len = '0;
    logic [15:0] pay = '0;
    logic [7:0]  per = 8'd1;
    logic        mod_o;
    logic        done_o;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    reply_framer #(.CLK_W(8), .BIT_CP(BIT), .GAP_CP(GAP), .WRESP_CP(WRESP),
                   .SOF_BITS(SOF), .MAX_BYTES(NBYTE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .len_bits_i(len),
        .payload_i(pay), .carrier_clks_i(per), .mod_o(mod_o), .done_o(done_o));

    function automatic logic exp_mod(int m, int tot, logic [15:0] p, int pe);
        int u, b, w, pi;
        logic bv;
        if (m < D * pe) return 1'b0;
        u = m - D * pe;
        b = u / (BIT * pe);
        if (b >= tot) return 1'b0;
        w = (u % (BIT * pe)) / pe;
        if (b < SOF) bv = 1'b1;
        else begin
            pi = b - SOF;
            bv = p[8 * (pi / 8) + 7 - (pi % 8)];
        end
        return bv ? (w < BIT / 2) : (w >= BIT / 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input vec_t v, input bit disturb);
        int pe, tot, end_m, first_hi, bad_m, bad_d;
        logic [15:0] p;
        pe  = (v.per == 0) ? 1 : int'(v.per);
        tot = SOF + ((v.len > MAXB) ? MAXB : int'(v.len));
        p   = v.pay;
        end_m = D * pe + tot * BIT * pe;
        first_hi = -1; bad_m = -1; bad_d = -1;
        @(negedge clk);
        len = v.len; pay = v.pay; per = v.per; start = 1'b1;
        @(posedge clk);
        for (int m = 0; m <= end_m + 2; m++) begin
            @(negedge clk);
            start = 1'b0;
            if (disturb && (m == 3 || m == D * pe + 6)) begin
                start = 1'b1; len = 5'd16; pay = 16'hFFFF; per = 8'd1;
            end
            if (mod_o && first_hi < 0) first_hi = m;
            if (mod_o !== exp_mod(m, tot, p, pe) && bad_m < 0) bad_m = m;
            if (done_o !== (m == end_m) && bad_d < 0) bad_d = m;
        end
        start = 1'b0;
        // R2: first modulated cycle after the shortened delay
        check(first_hi == D * pe, "R2 first modulation cycle", first_hi, D * pe);
        // R3/R4/R5/R7/R8/R9: full waveform
        check(bad_m < 0, disturb ? "R7 waveform under busy start" : "R3/R4/R5 waveform mismatch at cycle",
              bad_m, -1);
        // R6: single done strobe at end
        check(bad_d < 0, "R6 done strobe mismatch at cycle", bad_d, -1);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: held in reset
        check(mod_o == 1'b0, "R1 mod in reset", mod_o, 0);
        check(done_o == 1'b0, "R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: idle after reset without start
        check(mod_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", {mod_o, done_o}, 0);

        for (int k = 0; k < 6; k++) run_frame(VECS[k], 1'b0);

        // R7: start pulses and input changes during wait and send
        run_frame('{5'd8, 16'h0036, 8'd2}, 1'b1);

        repeat (3) @(negedge clk);
        check(mod_o == 1'b0 && done_o == 1'b0, "R6 idle after frames", {mod_o, done_o}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule